// File: doc/BRIEF.md
# Chunked Interrupt ID Allocator

This block hands out message-signalled interrupt IDs in fixed blocks of 32. It keeps one bit per block ("chunk") of the ID space. IDs below 8192 are reserved and are never handed out. Chunk `c` covers IDs `8192 + 32*c` to `8192 + 32*c + 31`. The number of chunks is `(2^ID_BITS - 8192) / 32`, where `ID_BITS` is an elaboration parameter.

An allocate request names how many interrupts a device wants. The block turns that count into a chunk count, rounding up, and searches the bitmap one chunk per clock. It looks for the lowest-indexed run of free chunks of that length. If a full pass finds no such run, the wanted length is reduced by one chunk and the search starts again from chunk 0. When a run is found, its chunks are marked used, one per clock. The block then returns the base ID and the granted ID count. If the length falls to zero, the request fails.

A free request names a base ID and an ID count. The block walks the chunks from the base upward and clears each one. Any chunk that was already free, lies outside the chunk range, or belongs to a base below the reserved floor raises an error flag and is left as it is.

The control path is a five-state machine:
- `ST_IDLE`: accepts a request.
- `ST_SCAN`: searches for a free run.
- `ST_MARK`: sets the chunks of the chosen run.
- `ST_FREE`: clears chunks during a free.
- `ST_DONE`: a one-cycle result.

Its transitions are:
- IDLE→SCAN on an allocate with a nonzero count.
- IDLE→FREE on a free with a nonzero count.
- IDLE→DONE on any zero count.
- SCAN→SCAN on a chunk step, or on a pass restart with one fewer chunk.
- SCAN→MARK when a run is found.
- SCAN→DONE when a one-chunk pass fails.
- MARK→DONE after the last chunk of the run.
- FREE→DONE after the last chunk walked.
- DONE→IDLE always.

Top module: `chunk_id_alloc`

## Requirements
- R1: After reset, every chunk is free, `req_ready` is 1, and `busy` and `done` are 0.
- R2: An allocate wants `ceil(req_count/32)` chunks. On success `done_count` equals granted chunks × 32, so its low 5 bits are always 0.
- R3: On success, `done_base` = 8192 + 32 × (index of the first chunk of the run). The run chosen is the lowest-indexed free run of the current length.
- R4: When no free run of the current length exists, the length drops by one chunk and the search repeats. When a one-chunk search fails, the result is `done_ok`=0 with `done_base`=0 and `done_count`=0.
- R5: Allocated chunks are marked used and are not granted again until they are freed.
- R6: A free clears `ceil(req_count/32)` chunks, starting at chunk `(req_base-8192)>>5`. Freed chunks can be granted again. A free with no error reports `done_ok`=1, `done_err`=0, `done_base`=0 and `done_count`=0.
- R7: Freeing a chunk that is already free leaves it free and gives `done_err`=1 and `done_ok`=0.
- R8: A free whose base is below 8192, or that walks past the last chunk, reports `done_err`=1 and changes no chunk for those positions.
- R9: A request is taken only while `req_ready`=1 (state IDLE). `req_valid` asserted while `busy`=1 has no effect.
- R10: Each state step handles one chunk per cycle. Count the edges after the accepting edge until `done` is high.
  - A found run costs (end index + 1) scan cycles for each successful pass, plus NCH cycles for each failed pass, plus one cycle per chunk marked.
  - A failed allocate costs (initial chunk count) × NCH cycles.
  - A free costs one cycle per chunk walked.
- R11: `done` is high for exactly one cycle per accepted request.
- R12: A zero count finishes at the accepting edge. An allocate with a zero count fails (`done_ok`=0). A free with a zero count succeeds with no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request is taken at this edge |
| req_op | input | 1 | 0 = allocate, 1 = free |
| req_base | input | ID_BITS | Base ID for a free |
| req_count | input | CNT_W | Interrupt count wanted or to release |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| done_ok | output | 1 | Request succeeded |
| done_err | output | 1 | Free touched a free or out-of-range chunk |
| done_base | output | ID_BITS | First granted ID (allocate success) |
| done_count | output | CNT_W+1 | Granted ID count (allocate success) |

## Verification
Every result is due at an exact number of edges after the accepting edge. That number is 0 for a zero count and one edge per chunk walked for a free. For an allocate it is the scan and mark cycles of R10: the bench's model adds up, pass by pass, the cycles the first-fit search spends on its copy of the bitmap. The bench samples on falling edges and counts edges from acceptance until `done` rises. It compares that count with the model's value, then checks the result fields in that same cycle, and checks that `done` is low one cycle later.

// File: rtl/cia_pkg.sv
package cia_pkg;
    localparam int unsigned CHUNK_SHIFT  = 5;
    localparam int unsigned RESERVED_IDS = 8192;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_MARK,
        ST_FREE,
        ST_DONE
    } cia_state_e;

    typedef enum logic {
        OP_ALLOC = 1'b0,
        OP_FREE  = 1'b1
    } cia_op_e;
endpackage

// File: rtl/cia_bitmap.sv
module cia_bitmap #(
    parameter int unsigned NCH   = 1792,
    parameter int unsigned IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_used,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val
);
    logic [NCH-1:0] used_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
        end else if (wr_en) begin
            used_q[wr_idx] <= wr_val;
        end
    end

    always_comb begin
        rd_used = used_q[rd_idx];
    end
endmodule

// File: rtl/cia_run_scan.sv
module cia_run_scan #(
    parameter int unsigned NCH    = 1792,
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned NEED_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              bit_used,
    input  logic [NEED_W-1:0] need,
    output logic [IDX_W-1:0]  idx,
    output logic              hit,
    output logic              last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NCH - 1);

    logic [NEED_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx   <= '0;
            run_q <= '0;
        end else if (restart) begin
            idx   <= '0;
            run_q <= '0;
        end else if (step) begin
            idx   <= idx + 1'b1;
            run_q <= bit_used ? '0 : run_q + 1'b1;
        end
    end

    always_comb begin
        last = (idx == LAST_IDX);
        hit  = !bit_used && (({1'b0, run_q} + 1'b1) == {1'b0, need});
    end
endmodule

// File: rtl/chunk_id_alloc.sv
module chunk_id_alloc
    import cia_pkg::*;
#(
    parameter int unsigned ID_BITS = 16,
    parameter int unsigned CNT_W   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic [ID_BITS-1:0] req_base,
    input  logic [CNT_W-1:0]   req_count,
    output logic               busy,
    output logic               done,
    output logic               done_ok,
    output logic               done_err,
    output logic [ID_BITS-1:0] done_base,
    output logic [CNT_W:0]     done_count
);
    localparam longint unsigned SPACE = 64'd1 << ID_BITS;
    localparam int unsigned NCH    = int'((SPACE - longint'(RESERVED_IDS)) >> CHUNK_SHIFT);
    localparam int unsigned IDX_W  = $clog2(NCH);
    localparam int unsigned NEED_W = CNT_W - CHUNK_SHIFT + 1;
    localparam int unsigned FIDX_W = ((IDX_W > NEED_W) ? IDX_W : NEED_W) + 1;
    localparam logic [FIDX_W-1:0]  NCH_F  = FIDX_W'(NCH);
    localparam logic [ID_BITS-1:0] FLOOR  = ID_BITS'(RESERVED_IDS);

    cia_state_e state_q, state_d;

    logic [NEED_W-1:0] need_q, mleft_q, fleft_q;
    logic [IDX_W-1:0]  start_q, mptr_q;
    logic [FIDX_W-1:0] fidx_q;
    logic              flow_q;
    logic              res_ok_q, res_err_q;
    logic [ID_BITS-1:0] res_base_q;
    logic [CNT_W:0]    res_cnt_q;

    logic              accept;
    logic              op_free;
    logic [CNT_W:0]    cnt_round;
    logic [NEED_W-1:0] need_in;
    logic [ID_BITS-1:0] base_off, base_sh;
    logic              base_low;

    logic [IDX_W-1:0]  scan_idx, hit_start, rd_idx, wr_idx;
    logic              scan_hit, scan_last, scan_restart, scan_step;
    logic              rd_used, wr_en, wr_val;
    logic              free_bad;

    always_comb begin
        accept    = req_valid && (state_q == ST_IDLE);
        op_free   = (cia_op_e'(req_op) == OP_FREE);
        cnt_round = {1'b0, req_count} + (CNT_W + 1)'(31);
        need_in   = cnt_round[CNT_W:CHUNK_SHIFT];
        base_off  = req_base - FLOOR;
        base_sh   = base_off >> CHUNK_SHIFT;
        base_low  = (req_base < FLOOR);
        hit_start = scan_idx - IDX_W'(need_q) + 1'b1;
        free_bad  = flow_q || (fidx_q >= NCH_F) || !rd_used;
    end

    // datapath helpers
    always_comb begin
        scan_restart = accept || ((state_q == ST_SCAN) && !scan_hit && scan_last);
        scan_step    = (state_q == ST_SCAN) && !scan_hit && !scan_last;
        rd_idx       = (state_q == ST_SCAN) ? scan_idx : fidx_q[IDX_W-1:0];
        wr_en        = (state_q == ST_MARK) || ((state_q == ST_FREE) && !free_bad);
        wr_idx       = (state_q == ST_MARK) ? mptr_q : fidx_q[IDX_W-1:0];
        wr_val       = (state_q == ST_MARK);
    end

    cia_bitmap #(.NCH(NCH), .IDX_W(IDX_W)) u_bitmap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_used (rd_used),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val)
    );

    cia_run_scan #(.NCH(NCH), .IDX_W(IDX_W), .NEED_W(NEED_W)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (scan_restart),
        .step     (scan_step),
        .bit_used (rd_used),
        .need     (need_q),
        .idx      (scan_idx),
        .hit      (scan_hit),
        .last     (scan_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (need_in == '0)  state_d = ST_DONE;
                    else if (op_free)   state_d = ST_FREE;
                    else                state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (scan_hit)                                   state_d = ST_MARK;
                else if (scan_last && (need_q == NEED_W'(1)))   state_d = ST_DONE;
            end
            ST_MARK: if (mleft_q == NEED_W'(1)) state_d = ST_DONE;
            ST_FREE: if (fleft_q == NEED_W'(1)) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // working registers and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            need_q     <= '0;
            mleft_q    <= '0;
            fleft_q    <= '0;
            start_q    <= '0;
            mptr_q     <= '0;
            fidx_q     <= '0;
            flow_q     <= 1'b0;
            res_ok_q   <= 1'b0;
            res_err_q  <= 1'b0;
            res_base_q <= '0;
            res_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        need_q     <= need_in;
                        fleft_q    <= need_in;
                        fidx_q     <= FIDX_W'(base_sh);
                        flow_q     <= base_low;
                        res_ok_q   <= op_free && (need_in == '0);
                        res_err_q  <= 1'b0;
                        res_base_q <= '0;
                        res_cnt_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    if (scan_hit) begin
                        start_q <= hit_start;
                        mptr_q  <= hit_start;
                        mleft_q <= need_q;
                    end else if (scan_last && (need_q != NEED_W'(1))) begin
                        need_q <= need_q - 1'b1;
                    end
                end
                ST_MARK: begin
                    mptr_q  <= mptr_q + 1'b1;
                    mleft_q <= mleft_q - 1'b1;
                    if (mleft_q == NEED_W'(1)) begin
                        res_ok_q   <= 1'b1;
                        res_base_q <= (ID_BITS'(start_q) << CHUNK_SHIFT) + FLOOR;
                        res_cnt_q  <= {need_q, {CHUNK_SHIFT{1'b0}}};
                    end
                end
                ST_FREE: begin
                    fidx_q  <= fidx_q + 1'b1;
                    fleft_q <= fleft_q - 1'b1;
                    if (free_bad) res_err_q <= 1'b1;
                    if (fleft_q == NEED_W'(1)) res_ok_q <= !(res_err_q || free_bad);
                end
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        done_ok    = res_ok_q;
        done_err   = res_err_q;
        done_base  = res_base_q;
        done_count = res_cnt_q;
    end
endmodule

// File: rtl/chunk_id_alloc_chk.sv
module chunk_id_alloc_chk #(
    parameter int unsigned ID_BITS = 16,
    parameter int unsigned CNT_W   = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               busy,
    input logic               done,
    input logic               done_ok,
    input logic               done_err,
    input logic [ID_BITS-1:0] done_base,
    input logic [CNT_W:0]     done_count
);
    localparam logic [ID_BITS-1:0] FLOOR = ID_BITS'(8192);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_granted_mult_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_count[4:0] == 5'd0));

    p_base_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_ok && (done_count != '0)) |-> ((done_base >= FLOOR) && (done_base[4:0] == 5'd0)));

    p_fail_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !done_ok) |-> ((done_base == '0) && (done_count == '0)));

    p_err_not_ok_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |-> !done_ok);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind chunk_id_alloc chunk_id_alloc_chk #(.ID_BITS(ID_BITS), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .done_ok    (done_ok),
    .done_err   (done_err),
    .done_base  (done_base),
    .done_count (done_count)
);

// File: tb/chunk_id_alloc_tb.sv
`timescale 1ns/1ps
module chunk_id_alloc_tb;
    localparam int ID_BITS = 14;
    localparam int CNT_W   = 10;
    localparam int NCH     = ((1 << ID_BITS) - 8192) >> 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_op = 1'b0;
    logic [ID_BITS-1:0] req_base = '0;
    logic [CNT_W-1:0]   req_count = '0;
    logic               busy, done, done_ok, done_err;
    logic [ID_BITS-1:0] done_base;
    logic [CNT_W:0]     done_count;

    int tests = 0;
    int fails = 0;
    bit mdl [NCH];
    int e_ok, e_base, e_cnt, e_err, e_lat;

    always #2.5 clk = ~clk;

    chunk_id_alloc #(.ID_BITS(ID_BITS), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_base(req_base), .req_count(req_count),
        .busy(busy), .done(done), .done_ok(done_ok), .done_err(done_err),
        .done_base(done_base), .done_count(done_count)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_alloc(input int count);
        int need0 = (count + 31) / 32;
        e_ok = 0; e_base = 0; e_cnt = 0; e_err = 0; e_lat = 0;
        for (int n = need0; n >= 1; n--) begin
            int run = 0;
            for (int i = 0; i < NCH; i++) begin
                run = mdl[i] ? 0 : run + 1;
                if (run == n) begin
                    e_lat += i + 1 + n;
                    for (int k = i - n + 1; k <= i; k++) mdl[k] = 1'b1;
                    e_ok = 1; e_base = 8192 + 32 * (i - n + 1); e_cnt = 32 * n;
                    return;
                end
            end
            e_lat += NCH;
        end
    endtask

    task automatic model_free(input int base, input int count);
        int need = (count + 31) / 32;
        int c0 = (base - 8192) >>> 5;
        e_base = 0; e_cnt = 0; e_err = 0; e_lat = need;
        for (int k = 0; k < need; k++) begin
            int c = c0 + k;
            if (base < 8192 || c >= NCH || !mdl[c]) e_err = 1;
            else mdl[c] = 1'b0;
        end
        e_ok = !e_err;
    endtask

    task automatic run_op(input bit op, input int base, input int count, input string tag);
        int lat = 0;
        if (op) model_free(base, count); else model_alloc(count);
        @(negedge clk);
        chk({tag, " R9 ready before issue"}, req_ready, 1);
        req_valid = 1'b1; req_op = op; req_base = ID_BITS'(base); req_count = CNT_W'(count);
        @(posedge clk);
        @(negedge clk);
        // R9: a request held while busy must be ignored (model ignores it)
        req_op = 1'b1; req_base = ID_BITS'(8192); req_count = CNT_W'(1023);
        while (!done && lat < 30000) begin
            @(negedge clk);
            lat++;
            req_valid = 1'b0;
        end
        req_valid = 1'b0;
        if (lat >= 30000) begin
            chk({tag, " R10 watchdog"}, lat, e_lat);
        end else begin
            chk({tag, " R10 latency"}, lat, e_lat);
            chk({tag, op ? " R6/R7 ok" : " R4 ok"}, done_ok, e_ok);
            chk({tag, " R7/R8 err"}, done_err, e_err);
            chk({tag, " R3 base"}, done_base, e_base);
            chk({tag, " R2 count"}, done_count, e_cnt);
            @(negedge clk);
            chk({tag, " R11 done pulse"}, done, 0);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog R10 actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NCH; i++) mdl[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ready", req_ready, 1);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after release", req_ready, 1);

        run_op(0, 0, 1, "R2 alloc one");
        run_op(0, 0, 33, "R2 alloc two chunks");
        run_op(0, 0, 0, "R12 alloc zero");
        run_op(1, 8192, 0, "R12 free zero");
        run_op(1, 8192 + 32, 32, "R6 free chunk1");
        run_op(0, 0, 20, "R3 R5 first fit reuse");
        run_op(1, 8192 + 32 * 100, 32, "R7 double free");
        run_op(1, 100, 32, "R8 below floor");
        run_op(1, 8192 + 32 * (NCH - 1), 64, "R8 past end");
        // fill the space to force shrink and fail
        for (int i = 0; i < 9; i++) run_op(0, 0, 1023, "R4 R5 big fill");
        run_op(0, 0, 1, "R4 full fail");
        run_op(1, 8192 + 32 * 10, 96, "R6 hole of three");
        run_op(1, 8192 + 32 * 50, 32, "R6 hole of one");
        run_op(0, 0, 200, "R4 shrink to three");
        run_op(0, 0, 64, "R4 shrink to one");
        run_op(1, 8192, 32 * 31, "R6 big free");
        run_op(1, 8192 + 32 * 40, 32 * 31, "R6 R7 mixed free");

        void'($urandom(32'd4242));
        for (int t = 0; t < 45; t++) begin
            bit op = $urandom % 2;
            if (op) run_op(1, 8192 + 32 * ($urandom % NCH), $urandom % 160, "R6 R7 R8 random free");
            else    run_op(0, 0, $urandom % 200, "R3 R4 R5 random alloc");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule